// File: doc/BRIEF.md
# SD Command Issue and Response Capture

This block issues one SD card command at a time. Software writes a command word, an argument and a configuration word through a small word-addressed register port. Setting the start bit in the command word launches a transaction. The block presents the 6-bit command index and the argument on a parallel card-side handshake. It then waits for the card side to acknowledge with a response byte count and up to sixteen response bytes, or with an error.

When the card side answers, the block checks the reported length against the response type that the command word requested. A valid short (4-byte) or long (16-byte) response is stored in four read-only response words. A length mismatch, a card-side error or a missing acknowledge marks the command as failed and raises a timeout status bit. Commands that ask for a busy wait can also raise a busy status bit. Serial line timing, CRC generation and checking, and clock division are handled elsewhere.

Top module: `sdc_cmd_issue`

## Requirements
- R1: The register map, by word address, is: 0 command, 1 argument, 2 configuration, 3 status, 4 to 7 response words 0 to 3. All registers reset to zero. The command register is 16 bits: index in bits 5:0, read flag bit 6, write flag bit 7, long-response flag bit 9, no-response flag bit 10, busy-wait flag bit 11, fail flag bit 14, start flag bit 15. It reads back as last written, except that hardware updates bits 14 and 15.
- R2: A command-register write with bit 15 set starts a command. From the next cycle `card_req` is high and stays high until the cycle of acknowledge or timeout. While it is high, `card_idx` equals command bits 5:0 and `card_arg` equals the argument register.
- R3: When a command completes, command bit 15 reads 0.
- R4: A valid 4-byte response puts card bytes 0..3 into response word 0, with byte 0 in bits 31:24, and clears words 1 to 3. Card byte k is carried on `card_data[127-8k -: 8]`.
- R5: A valid 16-byte response fills word 0 from bytes 12..15, word 1 from bytes 8..11, word 2 from bytes 4..7 and word 3 from bytes 0..3. In each word the lowest-numbered byte is the most significant.
- R6: When the no-response flag is clear, the following byte counts on `card_len` are errors: 0, 4 while the long flag is set, and any count other than 4 or 16. When the no-response flag is set, any count is accepted and the response words are left unchanged.
- R7: On any error the block sets command bit 14 and status bit 6, and the response words keep their previous values.
- R8: `card_err` asserted with the acknowledge is an error. So is the absence of any acknowledge for ACK_LIMIT cycles of `card_req`, after which `card_req` drops.
- R9: A successful command with busy-wait (command bit 11) set, while configuration bit 10 is 1, sets status bit 10. Otherwise bit 10 is not set.
- R10: A write to the status register clears every bit whose write-data bit is 1. A bit that is set in the same cycle stays set.
- R11: While a command is pending, writes to the command and argument registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| card_req | output | 1 | Command pending toward the card side |
| card_idx | output | 6 | Command index |
| card_arg | output | ARG_W | Command argument |
| card_ack | input | 1 | Card side answered (one cycle) |
| card_err | input | 1 | Card side reports failure with the acknowledge |
| card_len | input | 5 | Response length in bytes |
| card_data | input | 128 | Response bytes, byte 0 in the top bits |

## Verification
Two events can fall in the same cycle: the completion of a command, which sets the timeout or busy bit, and a software write-one-to-clear of the status register. The bench lines these up by driving the card acknowledge and a status write of all ones on the same clock edge. It then expects the bit that completion produced to read back as 1 while every older bit reads 0. Random commands with mixed flags, lengths, errors and interleaved status clears repeat this against a bench model of the status register.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
   localparam int CMD_W    = 16;
   localparam int STAT_W   = 11;
   localparam int CFG_W    = 11;
   localparam int IDX_W    = 6;
   localparam int LEN_W    = 5;
   localparam int RSP_WORDS = 4;
   localparam int RSP_W    = 32 * RSP_WORDS;

   // command word bit positions
   localparam int CB_LONG  = 9;
   localparam int CB_NORSP = 10;
   localparam int CB_BUSYW = 11;
   localparam int CB_FAIL  = 14;
   localparam int CB_NEW   = 15;

   // status and configuration bit positions
   localparam int SB_TMO   = 6;
   localparam int SB_BUSY  = 10;
   localparam int FB_BUSYEN = 10;

   // register word addresses
   localparam logic [2:0] RA_CMD  = 3'd0;
   localparam logic [2:0] RA_ARG  = 3'd1;
   localparam logic [2:0] RA_CFG  = 3'd2;
   localparam logic [2:0] RA_STAT = 3'd3;
endpackage

// File: rtl/sdc_issue_fsm.sv
module sdc_issue_fsm #(
   parameter int ACK_LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic card_ack,
   output logic busy_o,
   output logic done_o,
   output logic tmo_o
);
   localparam int CNT_W = $clog2(ACK_LIMIT + 1);

   if (ACK_LIMIT < 2) begin : g_bad_limit
      $error("sdc_issue_fsm: ACK_LIMIT must be at least 2");
   end

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;

   assign tmo_o  = busy_q && !card_ack && (cnt_q == CNT_W'(ACK_LIMIT - 1));
   assign done_o = busy_q && (card_ack || tmo_o);
   assign busy_o = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (done_o) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   // R8: the wait counter never passes the limit
   a_r8_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q < CNT_W'(ACK_LIMIT)));
   // R2: a pending command only begins after a start
   a_r2_rise_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(start));
endmodule

// File: rtl/sdc_rsp_check.sv
module sdc_rsp_check
   import sdc_pkg::*;
(
   input  logic             card_ack,
   input  logic             card_err,
   input  logic             tmo,
   input  logic             want_long,
   input  logic             no_rsp,
   input  logic [LEN_W-1:0] len,
   output logic             err_o,
   output logic             len16_o
);
   logic len_bad;

   always_comb begin
      len_bad = 1'b0;
      if (len != LEN_W'(4) && len != LEN_W'(16)) len_bad = 1'b1;
      if (len == LEN_W'(4) && want_long)         len_bad = 1'b1;
      if (len == '0)                             len_bad = 1'b1;
   end

   assign err_o   = tmo || (card_ack && (card_err || (!no_rsp && len_bad)));
   assign len16_o = (len == LEN_W'(16));
endmodule

// File: rtl/sdc_rsp_store.sv
module sdc_rsp_store
   import sdc_pkg::*;
(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       capture,
   input  logic                       len16,
   input  logic [RSP_W-1:0]           card_data,
   output logic [RSP_WORDS-1:0][31:0] words_o
);
   for (genvar i = 0; i < RSP_WORDS; i++) begin : g_word
      logic [31:0] short_val;
      if (i == 0) begin : g_low
         assign short_val = card_data[RSP_W-1 -: 32];
      end else begin : g_high
         assign short_val = '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       words_o[i] <= '0;
         else if (capture) words_o[i] <= len16 ? card_data[32*i +: 32] : short_val;
      end

      if (i > 0) begin : g_chk
         // R4: a short response leaves the upper words at zero
         a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (capture && !len16) |=> (words_o[i] == '0));
      end
   end
endmodule

// File: rtl/sdc_cmd_issue.sv
module sdc_cmd_issue
   import sdc_pkg::*;
#(
   parameter int ARG_W     = 32,
   parameter int ACK_LIMIT = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              card_req,
   output logic [IDX_W-1:0]  card_idx,
   output logic [ARG_W-1:0]  card_arg,
   input  logic              card_ack,
   input  logic              card_err,
   input  logic [LEN_W-1:0]  card_len,
   input  logic [RSP_W-1:0]  card_data
);
   if (ARG_W < 1 || ARG_W > 32) begin : g_bad_arg
      $error("sdc_cmd_issue: ARG_W must be 1..32");
   end

   logic [CMD_W-1:0]  cmd_q;
   logic [ARG_W-1:0]  arg_q;
   logic [CFG_W-1:0]  cfg_q;
   logic [STAT_W-1:0] stat_q;
   logic [RSP_WORDS-1:0][31:0] words;

   logic busy, done, tmo, err, len16;
   logic wr_cmd, wr_arg, wr_cfg, wr_stat, start, capture;
   logic [STAT_W-1:0] stat_set, stat_clr;

   assign wr_cmd  = reg_wr && reg_addr == RA_CMD && !busy;
   assign wr_arg  = reg_wr && reg_addr == RA_ARG && !busy;
   assign wr_cfg  = reg_wr && reg_addr == RA_CFG;
   assign wr_stat = reg_wr && reg_addr == RA_STAT;
   assign start   = wr_cmd && reg_wdata[CB_NEW];

   sdc_issue_fsm #(.ACK_LIMIT(ACK_LIMIT)) fsm_i (
      .clk(clk), .rst_n(rst_n), .start(start), .card_ack(card_ack),
      .busy_o(busy), .done_o(done), .tmo_o(tmo)
   );

   sdc_rsp_check chk_i (
      .card_ack(card_ack && busy), .card_err(card_err), .tmo(tmo),
      .want_long(cmd_q[CB_LONG]), .no_rsp(cmd_q[CB_NORSP]), .len(card_len),
      .err_o(err), .len16_o(len16)
   );

   assign capture = done && !err && !cmd_q[CB_NORSP];

   sdc_rsp_store store_i (
      .clk(clk), .rst_n(rst_n), .capture(capture), .len16(len16),
      .card_data(card_data), .words_o(words)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
         arg_q <= '0;
         cfg_q <= '0;
      end else begin
         if (wr_cmd) begin
            cmd_q <= reg_wdata[CMD_W-1:0];
         end else if (done) begin
            cmd_q[CB_NEW] <= 1'b0;
            if (err) cmd_q[CB_FAIL] <= 1'b1;
         end
         if (wr_arg) arg_q <= reg_wdata[ARG_W-1:0];
         if (wr_cfg) cfg_q <= reg_wdata[CFG_W-1:0];
      end
   end

   always_comb begin
      stat_set = '0;
      if (done && err) stat_set[SB_TMO] = 1'b1;
      if (done && !err && cmd_q[CB_BUSYW] && cfg_q[FB_BUSYEN]) stat_set[SB_BUSY] = 1'b1;
      stat_clr = wr_stat ? reg_wdata[STAT_W-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~stat_clr) | stat_set;
   end

   assign card_req = busy;
   assign card_idx = cmd_q[IDX_W-1:0];
   assign card_arg = arg_q;

   always_comb begin
      case (reg_addr)
         RA_CMD:  reg_rdata = 32'(cmd_q);
         RA_ARG:  reg_rdata = 32'(arg_q);
         RA_CFG:  reg_rdata = 32'(cfg_q);
         RA_STAT: reg_rdata = 32'(stat_q);
         default: reg_rdata = words[reg_addr[1:0]];
      endcase
   end

   // R3: start flag reads clear after completion
   a_r3_new_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !cmd_q[CB_NEW]);
   // R7: a failed command marks both the command and status registers
   a_r7_fail_marks: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |=> (cmd_q[CB_FAIL] && stat_q[SB_TMO]));
   // R11: argument register frozen while a command is pending
   a_r11_arg_locked: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(arg_q));
   // R9: busy status only rises with the enable on
   a_r9_busy_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[SB_BUSY]) |-> $past(cfg_q[FB_BUSYEN]));
   // R2: index stays put while the card side is served
   a_r2_idx_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (card_req && !card_ack) |=> $stable(card_idx));
endmodule

// File: tb/sdc_cmd_issue_tb_top.sv
`timescale 1ns/1ps
module sdc_cmd_issue_tb_top;
   localparam int LIMIT = 64;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_wr = 1'b0;
   logic [2:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic         card_req;
   logic [5:0]   card_idx;
   logic [31:0]  card_arg;
   logic         card_ack = 1'b0;
   logic         card_err = 1'b0;
   logic [4:0]   card_len = '0;
   logic [127:0] card_data = '0;

   int checks = 0;
   int errors = 0;

   logic [31:0] exp_rsp [4];
   logic [10:0] exp_stat;
   logic [10:0] exp_cfg;

   always #2 clk = ~clk;

   sdc_cmd_issue #(.ARG_W(32), .ACK_LIMIT(LIMIT)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .card_req(card_req),
      .card_idx(card_idx), .card_arg(card_arg), .card_ack(card_ack),
      .card_err(card_err), .card_len(card_len), .card_data(card_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   function automatic logic [127:0] pack_bytes(input logic [7:0] b [16]);
      logic [127:0] v = '0;
      for (int k = 0; k < 16; k++) v[127-8*k -: 8] = b[k];
      return v;
   endfunction

   function automatic logic model_err(input logic nores, input logic lng,
                                      input logic [4:0] len, input logic cerr);
      if (cerr) return 1'b1;
      if (nores) return 1'b0;
      if (len == 0) return 1'b1;
      if (len == 4 && lng) return 1'b1;
      return !(len == 4 || len == 16);
   endfunction

   // issue one command and check everything it should leave behind
   task automatic do_cmd(input logic [15:0] cmdw, input logic [31:0] argw, input int dly,
                         input logic cerr, input logic [4:0] len, input logic [7:0] b [16],
                         input bit noack, input bit intrude, input bit clash);
      logic [31:0] rd;
      logic        e;
      logic [15:0] expc;
      string       tag;
      reg_write(3'd1, argw);
      reg_write(3'd0, {16'h0, cmdw | 16'h8000});
      chk("R2 card_req", 32'(card_req), 32'd1);
      chk("R2 card_idx", 32'(card_idx), 32'(cmdw[5:0]));
      chk("R2 card_arg", card_arg, argw);
      if (intrude) begin
         reg_write(3'd1, ~argw);
         reg_write(3'd0, 32'h0000_803F);
         chk("R11 arg locked", card_arg, argw);
         chk("R11 idx locked", 32'(card_idx), 32'(cmdw[5:0]));
      end
      repeat (dly) @(negedge clk);
      if (noack) begin
         repeat (LIMIT + 2) @(negedge clk);
         chk("R8 req dropped", 32'(card_req), 32'd0);
         e = 1'b1;
      end else begin
         card_ack = 1'b1; card_err = cerr; card_len = len; card_data = pack_bytes(b);
         if (clash) begin
            reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h7FF;
         end
         @(negedge clk);
         card_ack = 1'b0; card_err = 1'b0; reg_wr = 1'b0;
         e = model_err(cmdw[10], cmdw[9], len, cerr);
         chk("R2 req released", 32'(card_req), 32'd0);
      end
      if (clash) exp_stat = '0;
      if (e) exp_stat[6] = 1'b1;
      else if (cmdw[11] && exp_cfg[10]) exp_stat[10] = 1'b1;
      if (!e && !cmdw[10]) begin
         if (len == 16) begin
            for (int w = 0; w < 4; w++)
               exp_rsp[w] = {b[12-4*w], b[13-4*w], b[14-4*w], b[15-4*w]};
         end else begin
            exp_rsp[0] = {b[0], b[1], b[2], b[3]};
            for (int w = 1; w < 4; w++) exp_rsp[w] = '0;
         end
      end
      expc = cmdw & 16'h7FFF;
      if (e) expc[14] = 1'b1;
      reg_read(3'd0, rd);
      chk(e ? "R7 fail bit" : "R3 start cleared", rd, 32'(expc));
      reg_read(3'd3, rd);
      chk(clash ? "R10 set beats clear" : (e ? "R7 status" : "R9 status"), rd, 32'(exp_stat));
      if (e) tag = "R7 words kept";
      else if (cmdw[10]) tag = "R6 no-response words kept";
      else if (len == 4) tag = "R4 short map";
      else tag = "R5 long map";
      for (int w = 0; w < 4; w++) begin
         reg_read(3'(4 + w), rd);
         chk(tag, rd, exp_rsp[w]);
      end
      if (intrude) begin
         reg_read(3'd1, rd);
         chk("R11 arg readback", rd, argw);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual running, expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      logic [7:0]  b [16];
      logic [4:0]  lens [6];
      logic [15:0] c;
      int          seed;
      seed = 7;
      void'($urandom(seed));
      lens[0] = 5'd0; lens[1] = 5'd4; lens[2] = 5'd16;
      lens[3] = 5'd3; lens[4] = 5'd8; lens[5] = 5'd20;
      for (int w = 0; w < 4; w++) exp_rsp[w] = '0;
      exp_stat = '0; exp_cfg = '0;
      for (int k = 0; k < 16; k++) b[k] = 8'(8'h10 + k);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int a = 0; a < 8; a++) begin
         reg_read(3'(a), rd);
         chk("R1 reset value", rd, 32'd0);
      end
      chk("R1 reset card_req", 32'(card_req), 32'd0);

      // readback without starting
      reg_write(3'd0, 32'h0000_4ED5);
      reg_read(3'd0, rd);
      chk("R1 readback", rd, 32'h4ED5);
      chk("R1 no start", 32'(card_req), 32'd0);
      reg_write(3'd0, 32'h0);

      reg_write(3'd2, 32'h400); exp_cfg = 11'h400;
      do_cmd(16'h0011, 32'h1234_5678, 2, 1'b0, 5'd4,  b, 0, 0, 0);   // R4
      do_cmd(16'h0202, 32'h0,         0, 1'b0, 5'd16, b, 0, 0, 0);   // R5
      do_cmd(16'h0003, 32'h1,         1, 1'b0, 5'd0,  b, 0, 0, 0);   // R6 zero length
      do_cmd(16'h0203, 32'h2,         1, 1'b0, 5'd4,  b, 0, 0, 0);   // R6 short on long
      do_cmd(16'h0004, 32'h3,         1, 1'b0, 5'd8,  b, 0, 0, 0);   // R6 odd length
      do_cmd(16'h0400, 32'h4,         1, 1'b0, 5'd0,  b, 0, 0, 0);   // R6 no response
      do_cmd(16'h0005, 32'h5,         1, 1'b1, 5'd4,  b, 0, 0, 0);   // R8 card error
      do_cmd(16'h0006, 32'h6,         0, 1'b0, 5'd4,  b, 1, 0, 0);   // R8 timeout
      do_cmd(16'h0807, 32'h7,         1, 1'b0, 5'd4,  b, 0, 0, 0);   // R9 busy enabled
      reg_write(3'd3, 32'h7FF); exp_stat = '0;
      reg_read(3'd3, rd);
      chk("R10 clear", rd, 32'd0);
      reg_write(3'd2, 32'h0); exp_cfg = '0;
      do_cmd(16'h0808, 32'h8,         1, 1'b0, 5'd4,  b, 0, 0, 0);   // R9 disabled
      reg_write(3'd2, 32'h400); exp_cfg = 11'h400;
      do_cmd(16'h0809, 32'h9,         1, 1'b0, 5'd0,  b, 0, 0, 0);   // R9 with error
      do_cmd(16'h000A, 32'hCAFE_F00D, 3, 1'b0, 5'd4,  b, 0, 1, 0);   // R11
      do_cmd(16'h080B, 32'hB,         2, 1'b0, 5'd16, b, 0, 0, 1);   // R10 clash
      do_cmd(16'h000C, 32'hC,         2, 1'b0, 5'd0,  b, 0, 0, 1);   // R10 clash error

      for (int it = 0; it < 300; it++) begin
         logic [31:0] m;
         for (int k = 0; k < 16; k++) b[k] = 8'($urandom);
         c = 16'($urandom) & 16'h0EFF;
         if ($urandom_range(0, 3) == 0) begin
            m = $urandom & 32'h7FF;
            reg_write(3'd3, m);
            exp_stat = exp_stat & ~m[10:0];
         end
         m = $urandom & 32'h7FF;
         reg_write(3'd2, m); exp_cfg = m[10:0];
         do_cmd(c, $urandom, $urandom_range(0, 5), ($urandom_range(0, 7) == 0),
                lens[$urandom_range(0, 5)], b, 0, 0, ($urandom_range(0, 4) == 0));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule